// File: doc/BRIEF.md
# Double-Buffered Synthesizer Divider Word Register

This block takes configuration writes for a fractional-N frequency synthesizer over a three-wire serial port (enable, serial clock, data). It keeps a 16-bit integer divider word and a 24-bit fractional divider word. Each word has a pending (shadow) copy and a live (active) copy. The active copies drive the divider datapath. A "hop" copies the pending values into the active outputs in a single system clock cycle, so the divider never sees a half-updated pair.

The register write that starts a hop depends on a stored mode bit. In fractional operation, an integer-word write only waits in the shadow copy. The next fractional-word write then commits both words together. In integer operation, an integer-word write commits at once and fractional-word writes are discarded. The commit point is the falling edge of the 31st serial clock of a frame, so the new frequency is applied before the frame's trailing pad clock. All three serial pins are synchronised into the system clock domain. The hop strobe is therefore a clean single-cycle pulse in that domain. The system clock must run several times faster than the serial clock.

Top module: `freq_hop_dbuf`

## Requirements
- R1: A frame is 32 serial clocks with enable high, sampled on the serial clock rising edge, MSB first: one write flag (1 = write), a 6-bit address, 24 data bits, then one pad bit; a frame whose flag is 0 changes nothing.
- R2: Address 0x0F holds the integer word, taken from the low 16 of the 24 data bits; address 0x10 holds the 24-bit fractional word.
- R3: Bit 3 of a write to address 0x12 sets the mode output (1 = integer, 0 = fractional); the other data bits do not affect it, and a mode write causes no hop.
- R4: In fractional mode, a write to 0x10 hops: active integer takes the shadow integer word and active fractional takes the written word.
- R5: In fractional mode, a write to 0x0F only updates the shadow integer word; outputs and hop strobe stay unchanged until the next 0x10 write.
- R6: In integer mode, a write to 0x0F hops at once with the new integer word and leaves the active fractional word unchanged; a write to 0x10 is ignored.
- R7: A committed write takes effect at the falling edge of the 31st serial clock, while enable is still high and before any 32nd clock.
- R8: A frame in which enable falls before the 31st serial clock leaves all words, the mode and the pending state unchanged.
- R9: After reset, the active and shadow words are zero, fractional mode is selected and the hop strobe is low.
- R10: The hop strobe is high for exactly one system clock cycle per hop, and the active words change only in that cycle.
- R11: Writes to any address other than 0x0F, 0x10 and 0x12 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_en | input | 1 | Serial frame enable, asynchronous |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| act_int | output | 16 | Active integer divider word |
| act_frac | output | 24 | Active fractional divider word |
| int_mode | output | 1 | 1 = integer mode, 0 = fractional mode |
| hop_strobe | output | 1 | One-cycle pulse when a hop commits |

## Verification
On every cycle, the assertions check the following: the hop strobe is a single-cycle pulse, and the active words never move without it. An integer-mode hop leaves the fractional word alone. A fractional-mode integer write produces no strobe. The reset values are also checked. Only the bench scenarios can show the mode-dependent pairing of shadow and active values across several frames. They also cover the commit point inside a frame that is still open, aborted and read frames being dropped, and the decode of the address and the mode-bit position.

// File: rtl/hop_pkg.sv
package hop_pkg;
    localparam int INT_W      = 16;
    localparam int FRAC_W     = 24;
    localparam int ADDR_W     = 6;
    localparam int FRAME_BITS = 32;
    localparam int PAYLOAD_W  = 1 + ADDR_W + FRAC_W;

    localparam logic [ADDR_W-1:0] INT_ADDR  = 6'h0F;
    localparam logic [ADDR_W-1:0] FRAC_ADDR = 6'h10;
    localparam logic [ADDR_W-1:0] MODE_ADDR = 6'h12;
    localparam int                MODE_BIT  = 3;

    typedef enum logic {MODE_FRAC = 1'b0, MODE_INT = 1'b1} hop_mode_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [FRAC_W-1:0] data;
    } frame_t;

    // A write hops when it targets the register that triggers in this mode.
    function automatic logic hop_trigger(hop_mode_e mode, logic [ADDR_W-1:0] addr);
        return (mode == MODE_INT) ? (addr == INT_ADDR) : (addr == FRAC_ADDR);
    endfunction
endpackage

// File: rtl/hop_serial_rx.sv
module hop_serial_rx
    import hop_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FRAME_LEN   = FRAME_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_en,
    input  logic              ser_clk,
    input  logic              ser_dat,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [FRAC_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(FRAME_LEN + 1);
    localparam logic [CNT_W-1:0] COMMIT_CNT = CNT_W'(PAYLOAD_W);
    localparam logic [CNT_W-1:0] LAST_CNT   = CNT_W'(FRAME_LEN);

    logic [SYNC_STAGES-1:0] en_p, clk_p, dat_p;
    logic                   en_s, clk_s, dat_s, clk_d;
    logic                   rise, fall;
    logic [CNT_W-1:0]       bit_cnt;
    frame_t                 shreg;

    assign en_s  = en_p[SYNC_STAGES-1];
    assign clk_s = clk_p[SYNC_STAGES-1];
    assign dat_s = dat_p[SYNC_STAGES-1];
    assign rise  = clk_s & ~clk_d;
    assign fall  = ~clk_s & clk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_p     <= '0;
            clk_p    <= '0;
            dat_p    <= '0;
            clk_d    <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= '0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            en_p     <= {en_p[SYNC_STAGES-2:0], ser_en};
            clk_p    <= {clk_p[SYNC_STAGES-2:0], ser_clk};
            dat_p    <= {dat_p[SYNC_STAGES-2:0], ser_dat};
            clk_d    <= clk_s;
            wr_valid <= 1'b0;
            if (!en_s) begin
                bit_cnt <= '0;
            end else if (rise && bit_cnt != LAST_CNT) begin
                shreg   <= {shreg[PAYLOAD_W-2:0], dat_s};
                bit_cnt <= bit_cnt + 1'b1;
            end else if (fall && bit_cnt == COMMIT_CNT && shreg.wr) begin
                wr_valid <= 1'b1;
                wr_addr  <= shreg.addr;
                wr_data  <= shreg.data;
            end
        end
    end
endmodule

// File: rtl/hop_reg_bank.sv
module hop_reg_bank
    import hop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [FRAC_W-1:0] wr_data,
    output logic [INT_W-1:0]  act_int,
    output logic [FRAC_W-1:0] act_frac,
    output logic              int_mode,
    output logic              hop_strobe
);
    logic [INT_W-1:0] sh_int;
    hop_mode_e        mode;
    logic             hop_now;

    assign int_mode = (mode == MODE_INT);
    assign hop_now  = wr_valid && hop_trigger(mode, wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_int     <= '0;
            act_int    <= '0;
            act_frac   <= '0;
            mode       <= MODE_FRAC;
            hop_strobe <= 1'b0;
        end else begin
            hop_strobe <= hop_now;
            if (wr_valid && wr_addr == INT_ADDR)
                sh_int <= wr_data[INT_W-1:0];
            if (wr_valid && wr_addr == MODE_ADDR)
                mode <= hop_mode_e'(wr_data[MODE_BIT]);
            if (hop_now) begin
                if (mode == MODE_INT) begin
                    act_int <= wr_data[INT_W-1:0];
                end else begin
                    act_int  <= sh_int;
                    act_frac <= wr_data;
                end
            end
        end
    end

    // R10
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        hop_strobe |=> !hop_strobe);

    // R10
    act_change_chk: assert property (@(posedge clk) disable iff (rst)
        (act_int != $past(act_int) || act_frac != $past(act_frac)) |-> hop_strobe);

    // R6
    int_frac_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hop_strobe && int_mode) |-> act_frac == $past(act_frac));

    // R5
    frac_int_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_addr == INT_ADDR && !int_mode) |=> !hop_strobe);

    // R9
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (act_int == '0 && act_frac == '0 && !int_mode && !hop_strobe));
endmodule

// File: rtl/freq_hop_dbuf.sv
module freq_hop_dbuf
    import hop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_en,
    input  logic              ser_clk,
    input  logic              ser_dat,
    output logic [INT_W-1:0]  act_int,
    output logic [FRAC_W-1:0] act_frac,
    output logic              int_mode,
    output logic              hop_strobe
);
    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [FRAC_W-1:0] wr_data;

    hop_serial_rx #(.SYNC_STAGES(2), .FRAME_LEN(FRAME_BITS)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .ser_en   (ser_en),
        .ser_clk  (ser_clk),
        .ser_dat  (ser_dat),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    hop_reg_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .act_int    (act_int),
        .act_frac   (act_frac),
        .int_mode   (int_mode),
        .hop_strobe (hop_strobe)
    );
endmodule

// File: tb/freq_hop_dbuf_test.sv
module freq_hop_dbuf_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  HALF_SER   = 8;

    logic        clk = 1'b0, rst = 1'b1;
    logic        ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
    logic [15:0] act_int;
    logic [23:0] act_frac;
    logic        int_mode, hop_strobe;

    int checks = 0, fails = 0, hops = 0;
    bit done = 0;

    // reference model state
    logic [15:0] m_sh_int = '0, m_int = '0;
    logic [23:0] m_frac = '0;
    logic        m_mode = 1'b0;
    int          m_hops = 0;

    freq_hop_dbuf uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_val(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check_val({req, " act_int"}, 32'(act_int), 32'(m_int));
        check_val({req, " act_frac"}, 32'(act_frac), 32'(m_frac));
        check_val({req, " int_mode"}, 32'(int_mode), 32'(m_mode));
        check_val({req, " hop count"}, 32'(hops), 32'(m_hops));
    endtask

    task automatic model_write(logic wr, logic [5:0] a, logic [23:0] d);
        if (!wr) return;
        if (a == 6'h0F) begin
            m_sh_int = d[15:0];
            if (m_mode) begin m_int = d[15:0]; m_hops++; end
        end else if (a == 6'h10) begin
            if (!m_mode) begin m_int = m_sh_int; m_frac = d; m_hops++; end
        end else if (a == 6'h12) begin
            m_mode = d[3];
        end
    endtask

    task automatic wait_ser(int n);
        repeat (n) @(negedge clk);
    endtask

    // drives nclk serial clocks; drops enable afterwards when close is set
    task automatic frame(logic wr, logic [5:0] a, logic [23:0] d, int nclk, bit close);
        logic [31:0] bits;
        bits = {wr, a, d, 1'b0};
        @(negedge clk);
        ser_en = 1'b1;
        wait_ser(HALF_SER);
        for (int i = 0; i < nclk; i++) begin
            ser_dat = bits[31-i];
            wait_ser(HALF_SER);
            ser_clk = 1'b1;
            wait_ser(HALF_SER);
            ser_clk = 1'b0;
        end
        wait_ser(HALF_SER);
        if (close) begin
            ser_en = 1'b0;
            wait_ser(12);
        end
        if (nclk >= 31) model_write(wr, a, d);
    endtask

    // every-clock comparison against model behaviour of the strobe
    logic [15:0] p_int;
    logic [23:0] p_frac;
    logic        p_strobe;
    bit          p_ok = 0;
    always @(negedge clk) begin
        if (rst) begin
            p_ok = 0;
        end else begin
            if (hop_strobe) hops++;
            if (p_ok) begin
                // R10
                checks++;
                if (hop_strobe && p_strobe) begin
                    fails++;
                    $display("FAIL R10 strobe width actual=2+ expected=1");
                end
                checks++;
                if ((act_int !== p_int || act_frac !== p_frac) && !hop_strobe) begin
                    fails++;
                    $display("FAIL R10 words moved without strobe actual=%h/%h expected=%h/%h",
                             act_int, act_frac, p_int, p_frac);
                end
            end
            p_int = act_int; p_frac = act_frac; p_strobe = hop_strobe; p_ok = 1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        wait_ser(4);
        check_all("R9 reset");

        // R5: pending integer write in fractional mode
        frame(1, 6'h0F, 24'h00005C, 32, 1);
        check_all("R5 int write pending");
        // R4 / R2: fractional write commits both
        frame(1, 6'h10, 24'h000001, 32, 1);
        check_all("R4 frac hop");
        frame(1, 6'h0F, 24'hA5007E, 32, 1);
        check_all("R5 second pending");
        frame(1, 6'h10, 24'h001062, 32, 1);
        check_all("R2 low 16 bits and R4 hop");

        // R1: read frame has no effect
        frame(0, 6'h10, 24'hABCDEF, 32, 1);
        check_all("R1 read frame");
        // R8: aborted frames
        frame(1, 6'h10, 24'h777777, 30, 1);
        check_all("R8 abort frac");
        frame(1, 6'h12, 24'h000008, 20, 1);
        check_all("R8 abort mode");
        // R11: other addresses
        frame(1, 6'h11, 24'hFFFFFF, 32, 1);
        frame(1, 6'h13, 24'hFFFFFF, 32, 1);
        check_all("R11 other address");

        // R3: enter integer mode, no hop
        frame(1, 6'h12, 24'h000008, 32, 1);
        check_all("R3 mode set");
        // R6: integer-mode hop, frac untouched
        frame(1, 6'h0F, 24'h001234, 32, 1);
        check_all("R6 int hop");
        frame(1, 6'h10, 24'h555555, 32, 1);
        check_all("R6 frac ignored");

        // R7: commit with enable still high after the 31st clock
        frame(1, 6'h0F, 24'h00BEEF, 31, 0);
        check_all("R7 commit before 32nd clock");
        check_val("R7 enable still high", 32'(ser_en), 32'd1);
        ser_en = 1'b0;
        wait_ser(12);

        // R3: back to fractional; shadow integer carried into the hop
        frame(1, 6'h12, 24'h000000, 32, 1);
        check_all("R3 mode clear");
        frame(1, 6'h10, 24'h00ABCD, 32, 1);
        check_all("R4 shadow carry");
        // R3: only bit 3 matters
        frame(1, 6'h12, 24'hFFFFF7, 32, 1);
        check_all("R3 bit position");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule